// File: doc/BRIEF.md
# Compare-Match IRQ Timer with Count Readback

This block is a 16-bit up-counter paired with a 16-bit programmable target register. Software loads the target one byte at a time through two bus addresses, and the top bit of the target doubles as the run enable. While the timer runs, every CPU-cycle strobe compares the count with the target. On a match the block raises an interrupt and the count stops where it is. When there is no match, the count advances by one.

The same two addresses return the live count when read, so software can poll the timer. Loading the high target byte with its top bit clear stops the timer and presets the count to the midpoint value 0x8000. A later write with the top bit set restarts it from there. The interrupt stays raised until software writes either target byte.

Top module: `match_tick_timer`

## Requirements
- R1: After reset the count is 0xFFFF, the target is 0x0000, `irq_o` is low and `bus_rdata` is 0x00.
- R2: A write to address 0x440C loads the data byte into target bits 15:8 and drives `irq_o` low after that clock edge.
- R3: A write to 0x440C whose data bit 7 is 0 sets the count to 0x8000 at that edge. This takes priority over a `cpu_tick` in the same cycle.
- R4: A write to 0x440D loads the data byte into target bits 7:0 and drives `irq_o` low after that clock edge.
- R5: While target bit 15 is 1, each cycle with `cpu_tick` high and the count not equal to the target adds one to the count. The count wraps from 0xFFFF to 0x0000.
- R6: While target bit 15 is 1, a `cpu_tick` cycle in which the count equals the target and the count is not 0xFFFF sets `irq_o` high at that edge and leaves the count unchanged.
- R7: A count of 0xFFFF never matches. With the target at 0xFFFF, the count passes through 0xFFFF to 0x0000 and `irq_o` stays low.
- R8: While target bit 15 is 0, `cpu_tick` does not change the count and does not raise `irq_o`.
- R9: `bus_rd` with address 0x440C loads count bits 15:8 into `bus_rdata` at the next edge, and 0x440D loads count bits 7:0. A read of any other address loads 0x00.
- R10: `irq_o` stays high until a target write. If a target write and a matching `cpu_tick` fall in the same cycle, the clear wins, and the next matching tick raises `irq_o` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tick | input | 1 | One-cycle strobe per CPU cycle |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, level, sticky |

## Verification
Two functions of this block can land on the same clock edge. A target write can meet a matching `cpu_tick`, and a preset write can meet a counting tick. The bench drives both strobes in one cycle while a match is already held. It then expects `irq_o` low after that edge and high again after the next tick. It also writes the high byte with bit 7 clear while a tick is present, and expects the readback to show exactly 0x8000 rather than 0x8001.

// File: rtl/mtt_pkg.sv
`timescale 1ns/1ps
package mtt_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mtt_decode.sv
`timescale 1ns/1ps
module mtt_decode #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h440C,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h440D
) (
  input  logic [ADDR_W-1:0] addr,
  output mtt_pkg::reg_sel_e sel
);
  always_comb begin
    if (addr == HI_ADDR)      sel = mtt_pkg::SEL_HI;
    else if (addr == LO_ADDR) sel = mtt_pkg::SEL_LO;
    else                      sel = mtt_pkg::SEL_NONE;
  end
endmodule

// File: rtl/mtt_target.sv
`timescale 1ns/1ps
module mtt_target #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  mtt_pkg::reg_sel_e sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  target,
  output logic              load_preset,
  output logic              irq_clear
);
  // byte lane 1 is the high half (also carries the run enable)
  for (genvar b = 0; b < 2; b++) begin : g_lane
    localparam mtt_pkg::reg_sel_e LANE_SEL = (b == 1) ? mtt_pkg::SEL_HI : mtt_pkg::SEL_LO;
    always_ff @(posedge clk) begin
      if (rst)
        target[b*DATA_W +: DATA_W] <= '0;
      else if (wr && sel == LANE_SEL)
        target[b*DATA_W +: DATA_W] <= wdata;
    end
  end

  assign load_preset = wr && (sel == mtt_pkg::SEL_HI) && !wdata[DATA_W-1];
  assign irq_clear   = wr && (sel != mtt_pkg::SEL_NONE);
endmodule

// File: rtl/mtt_core.sv
`timescale 1ns/1ps
module mtt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  input  logic             load_preset,
  input  logic             irq_clear,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] PRESET   = {1'b1, {(CNT_W-1){1'b0}}};

  logic run;
  logic hit;

  assign run = target[CNT_W-1];
  assign hit = run && (count == target) && (count != ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= ALL_ONES;
      irq   <= 1'b0;
    end else begin
      if (load_preset)
        count <= PRESET;
      else if (tick && run && !hit)
        count <= count + 1'b1;

      if (irq_clear)
        irq <= 1'b0;
      else if (tick && hit)
        irq <= 1'b1;
    end
  end
endmodule

// File: rtl/mtt_readback.sv
`timescale 1ns/1ps
module mtt_readback #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  mtt_pkg::reg_sel_e sel,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd) begin
      case (sel)
        mtt_pkg::SEL_HI: rdata <= count[CNT_W-1 -: DATA_W];
        mtt_pkg::SEL_LO: rdata <= count[DATA_W-1:0];
        default:         rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/match_tick_timer.sv
`timescale 1ns/1ps
module match_tick_timer #(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h440C,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h440D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  mtt_pkg::reg_sel_e sel;
  logic [CNT_W-1:0]  target;
  logic [CNT_W-1:0]  count;
  logic              load_preset;
  logic              irq_clear;

  mtt_decode #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  mtt_target #(.DATA_W(DATA_W)) u_tgt (
    .clk         (clk),
    .rst         (rst),
    .wr          (bus_wr),
    .sel         (sel),
    .wdata       (bus_wdata),
    .target      (target),
    .load_preset (load_preset),
    .irq_clear   (irq_clear)
  );

  mtt_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .tick        (cpu_tick),
    .target      (target),
    .load_preset (load_preset),
    .irq_clear   (irq_clear),
    .count       (count),
    .irq         (irq_o)
  );

  mtt_readback #(.DATA_W(DATA_W)) u_rb (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .sel   (sel),
    .count (count),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/match_tick_timer_chk.sv
`timescale 1ns/1ps
module match_tick_timer_chk #(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h440C,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h440D,
  localparam int               CNT_W   = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  target
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] PRESET   = {1'b1, {(CNT_W-1){1'b0}}};

  logic wr_hit;
  assign wr_hit = bus_wr && (bus_addr == HI_ADDR || bus_addr == LO_ADDR);

  // R2 R4 R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !irq_o);

  // R3
  preset_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == HI_ADDR && !bus_wdata[DATA_W-1]) |=> (count == PRESET));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_tick && target[CNT_W-1] && count != target && !wr_hit)
      |=> (count == $past(count) + 1'b1));

  // R6
  match_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_tick && target[CNT_W-1] && count == target && count != ALL_ONES && !wr_hit)
      |=> (irq_o && $stable(count)));

  // R7
  no_ones_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_tick && target[CNT_W-1] && count == ALL_ONES && !wr_hit && !irq_o)
      |=> (!irq_o && count == '0));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!target[CNT_W-1] && !wr_hit) |=> ($stable(count) && !$rose(irq_o)));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !wr_hit) |=> irq_o);
endmodule

bind match_tick_timer match_tick_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_tick  (cpu_tick),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .count     (count),
  .target    (target)
);

// File: tb/match_tick_timer_test.sv
`timescale 1ns/1ps
module match_tick_timer_test;
  localparam logic [15:0] A_HI = 16'h440C;
  localparam logic [15:0] A_LO = 16'h440D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_tick = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  match_tick_timer uut (
    .clk(clk), .rst(rst), .cpu_tick(cpu_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_count(output logic [15:0] c);
    logic [7:0] h, l;
    rd(A_HI, h);
    rd(A_LO, l);
    c = {h, l};
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      cpu_tick = 1'b1;
      repeat (n) @(negedge clk);
      cpu_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    logic [7:0]  d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 rdata", bus_rdata, 0);
    read_count(c);
    check("R1 count", c, 16'hFFFF);

    // R8 target 0 means stopped
    ticks(5);
    read_count(c);
    check("R8 frozen count", c, 16'hFFFF);
    check("R8 no irq", irq_o, 0);

    // R9 unmapped read returns zero
    rd(16'h440E, d);
    check("R9 other addr", d, 0);

    // sweep: R2 R3 R4 R5 R6
    for (int off = 0; off < 16; off++) begin
      for (int m = 0; m < 3; m++) begin
        int n;
        logic [15:0] ec;
        n = off + m;
        wr(A_HI, 8'h00);
        wr(A_LO, off[7:0]);
        wr(A_HI, 8'h80);
        ticks(n);
        ec = (n <= off) ? 16'h8000 + 16'(n) : 16'h8000 + 16'(off);
        read_count(c);
        check("R5 R6 sweep count", c, ec);
        check("R6 sweep irq", irq_o, (n > off) ? 1 : 0);
      end
    end

    // R10 sticky, R4 clear on low write
    wr(A_HI, 8'h00);
    wr(A_LO, 8'h03);
    wr(A_HI, 8'h80);
    ticks(15);
    check("R10 still high", irq_o, 1);
    read_count(c);
    check("R6 held count", c, 16'h8003);
    wr(A_LO, 8'h40);
    check("R4 clear", irq_o, 0);
    ticks(2);
    read_count(c);
    check("R5 resumes", c, 16'h8005);

    // R2 clear on high write, bit7 set keeps count
    wr(A_LO, 8'h05);
    ticks(1);
    check("R6 raise", irq_o, 1);
    wr(A_HI, 8'h80);
    check("R2 clear", irq_o, 0);
    read_count(c);
    check("R2 no preset", c, 16'h8005);

    // R10 clear wins over same-cycle match
    ticks(1);
    check("R6 raise again", irq_o, 1);
    @(negedge clk);
    cpu_tick = 1'b1; bus_wr = 1'b1; bus_addr = A_LO; bus_wdata = 8'h05;
    @(negedge clk);
    cpu_tick = 1'b0; bus_wr = 1'b0;
    check("R10 clear wins", irq_o, 0);
    ticks(1);
    check("R10 re-raise", irq_o, 1);

    // R3 preset beats same-cycle tick
    wr(A_LO, 8'h50);
    ticks(3);
    @(negedge clk);
    cpu_tick = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = 8'h00;
    @(negedge clk);
    cpu_tick = 1'b0; bus_wr = 1'b0;
    read_count(c);
    check("R3 preset priority", c, 16'h8000);
    ticks(4);
    read_count(c);
    check("R8 frozen after preset", c, 16'h8000);

    // R7 0xFFFF never matches
    wr(A_LO, 8'hFF);
    wr(A_HI, 8'hFF);
    ticks(32767);
    read_count(c);
    check("R7 reach ffff", c, 16'hFFFF);
    check("R7 no irq at ffff", irq_o, 0);
    ticks(1);
    read_count(c);
    check("R7 wrap", c, 16'h0000);
    check("R7 no irq after wrap", irq_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule